// File: doc/BRIEF.md
# ADC Configuration and Conversion Sequencer

This block is the register-side control for a successive-approximation converter. Software writes a configuration byte and a control byte. The configuration byte holds reference select, result alignment and the low channel bits. The control byte holds enable, start, a sticky completion flag, the top channel bit and a clock-divider select. The block drives the active reference code and the active 6-bit channel to the analog front end. Each setting has its own rule for when a new value reaches those outputs. The reference locks at the first conversion start and stays locked until the converter is disabled and enabled again. A channel change made during a conversion waits until that conversion ends. The alignment bit changes the readout at once.

A conversion is modelled inside the block. It lasts a fixed number of converter clock ticks, and the tick comes from a power-of-two prescaler on the system clock. When the conversion completes, the block captures the 10-bit value on `conv_result`. It then presents that value as two bytes, right-adjusted or left-adjusted.

A sequencer with four states runs the converter:
- `ST_OFF`: disabled.
- `ST_IDLE`: enabled, reference still unlocked.
- `ST_CONV`: converting.
- `ST_HOLD`: enabled and idle, reference locked.

Its transitions:
- Any state goes to `ST_OFF` when enable is low.
- `ST_OFF` goes to `ST_IDLE` once enable is high.
- `ST_OFF` or `ST_IDLE` goes to `ST_CONV` on an accepted start. This is the first lock of the reference.
- `ST_CONV` goes to `ST_HOLD` on the final tick, which is completion.
- `ST_HOLD` goes to `ST_CONV` on an accepted start.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, all four readable bytes read 0x00, `act_ref` and `act_chan` are 0 and `conv_active` is 0.
- R2: While the reference is unlocked (`ST_OFF`/`ST_IDLE`), `act_ref` follows configuration bits 7:6 one cycle after the write. The codes are 00 = external pin with the internal reference off, 01 = analog supply, 10 = internal 1.5 V and 11 = internal 1.6 V.
- R3: From an accepted start, `act_ref` holds its value, ignoring writes to bits 7:6, until enable (control bit 7) has been written 0 and then 1.
- R4: `act_chan` = {control bit 3, configuration bits 4:0}. It follows writes one cycle later, except during a conversion. Then it keeps the old value and takes the new one once that conversion completes.
- R5: The data bytes are at address 2 (low) and address 3 (high). With configuration bit 5 = 0, low = result[7:0] and high = {000000, result[9:8]}. With bit 5 = 1, high = result[9:2] and low = {result[1:0], 000000}. A change of bit 5 alters the readout in the cycle after the write, even mid-conversion.
- R6: Writing control bit 6 = 1 while enable is already 1 starts a conversion. Control bit 6 and `conv_active` read 1 for exactly CONV_TICKS × 2^(psel+1) cycles.
- R7: Completion sets control bit 4. Writing 0 there has no effect. Writing 1 clears it.
- R8: A start written while enable is 0 is ignored, and so is a start in the same write that sets enable.
- R9: Writing enable = 0 during a conversion ends it in the next cycle, without setting control bit 4 or capturing a result.
- R10: At completion, `conv_result` is captured, and the data bytes then show it.
- R11: Control bits 2:0 (psel) set the converter tick period to 2^(psel+1) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 config, 1 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address (0 config, 1 control, 2 data low, 3 data high) |
| rd_data | output | 8 | Combinational read data |
| conv_result | input | 10 | Converter output value, captured at completion |
| act_ref | output | 2 | Reference code applied to the front end |
| act_chan | output | 6 | Channel applied to the front end |
| conv_active | output | 1 | High while a conversion runs |

## Verification
A sequencer stuck in the wrong state shows in control bit 6 and `conv_active` within one system cycle, or at the expected completion cycle, which the bench samples to the exact cycle. A lock that is missed or released early shows on `act_ref` as soon as the next configuration write is given one cycle to land. A deferred channel applied too early shows on `act_chan` within two cycles of the mid-conversion write. A formatting or capture fault shows on the next read of address 2 or 3.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_CONV = 2'd2,
        ST_HOLD = 2'd3
    } adc_state_t;

    localparam logic [1:0] A_CFG = 2'd0;
    localparam logic [1:0] A_CTL = 2'd1;
    localparam logic [1:0] A_DLO = 2'd2;
    localparam logic [1:0] A_DHI = 2'd3;

    localparam int CTL_EN    = 7;
    localparam int CTL_START = 6;
    localparam int CTL_DONE  = 4;
    localparam int CTL_CHHI  = 3;

    localparam int CFG_LADJ  = 5;
endpackage

// File: rtl/adc_presc.sv
module adc_presc #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int CNT_W = 1 << PSEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i <= int'(psel)) limit[i] = 1'b1;
        end
    end

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clr || !run)  cnt_q <= '0;
        else if (tick)         cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_ctrl_pkg::*;
#(
    parameter int CONV_TICKS = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       start_req,
    input  logic       tick,
    output adc_state_t state,
    output logic       start_ok,
    output logic       done_evt,
    output logic       unlocked
);
    localparam int CW = $clog2(CONV_TICKS + 1);

    adc_state_t    state_d;
    logic [CW-1:0] tcnt_q;
    logic          last_tick;

    assign last_tick = tick && (tcnt_q == CW'(CONV_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:  if (en) state_d = start_req ? ST_CONV : ST_IDLE;
            ST_IDLE: if (!en) state_d = ST_OFF;
                     else if (start_req) state_d = ST_CONV;
            ST_CONV: if (!en) state_d = ST_OFF;
                     else if (last_tick) state_d = ST_HOLD;
            ST_HOLD: if (!en) state_d = ST_OFF;
                     else if (start_req) state_d = ST_CONV;
        endcase
    end

    always_comb begin
        start_ok = 1'b0;
        done_evt = 1'b0;
        unlocked = 1'b0;
        unique case (state)
            ST_OFF:  begin unlocked = 1'b1; start_ok = en && start_req; end
            ST_IDLE: begin unlocked = 1'b1; start_ok = en && start_req; end
            ST_CONV: done_evt = en && last_tick;
            ST_HOLD: start_ok = en && start_req;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          tcnt_q <= '0;
        else if (start_ok)                   tcnt_q <= '0;
        else if (state == ST_CONV && tick)   tcnt_q <= tcnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_fmt.sv
module adc_fmt #(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] res,
    input  logic             left,
    output logic [7:0]       lo,
    output logic [7:0]       hi
);
    localparam int PAD = 16 - RES_W;

    logic [15:0] word;

    generate
        if (PAD == 0) begin : g_full
            assign word = res;
        end else begin : g_pad
            assign word = left ? {res, {PAD{1'b0}}} : {{PAD{1'b0}}, res};
        end
    endgenerate

    assign lo = word[7:0];
    assign hi = word[15:8];
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CONV_TICKS = 13,
    parameter int PSEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic [RES_W-1:0] conv_result,
    output logic [1:0]       act_ref,
    output logic [5:0]       act_chan,
    output logic             conv_active
);
    logic [7:0]        cfg_q;
    logic              en_q;
    logic              chhi_q;
    logic [PSEL_W-1:0] psel_q;
    logic              done_q;
    logic [RES_W-1:0]  res_q;

    logic       wr_cfg, wr_ctl;
    logic       start_req, start_ok, done_evt, unlocked, tick, busy;
    adc_state_t state;
    logic [7:0] d_lo, d_hi;

    assign wr_cfg    = wr_en && (wr_addr == A_CFG);
    assign wr_ctl    = wr_en && (wr_addr == A_CTL);
    assign start_req = wr_ctl && wr_data[CTL_START];
    assign busy      = (state == ST_CONV);
    assign conv_active = busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            en_q   <= 1'b0;
            chhi_q <= 1'b0;
            psel_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= wr_data;
            if (wr_ctl) begin
                en_q   <= wr_data[CTL_EN];
                chhi_q <= wr_data[CTL_CHHI];
                psel_q <= wr_data[PSEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         done_q <= 1'b0;
        else if (done_evt)                  done_q <= 1'b1;
        else if (wr_ctl && wr_data[CTL_DONE]) done_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_q <= '0;
        else if (done_evt) res_q <= conv_result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ref  <= 2'b00;
            act_chan <= '0;
        end else begin
            if (unlocked) act_ref  <= cfg_q[7:6];
            if (!busy)    act_chan <= {chhi_q, cfg_q[4:0]};
        end
    end

    adc_presc #(.PSEL_W(PSEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .run   (busy),
        .psel  (psel_q),
        .tick  (tick)
    );

    adc_seq #(.CONV_TICKS(CONV_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .start_req (start_req),
        .tick      (tick),
        .state     (state),
        .start_ok  (start_ok),
        .done_evt  (done_evt),
        .unlocked  (unlocked)
    );

    adc_fmt #(.RES_W(RES_W)) u_fmt (
        .res  (res_q),
        .left (cfg_q[CFG_LADJ]),
        .lo   (d_lo),
        .hi   (d_hi)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CFG: rd_data = cfg_q;
            A_CTL: begin
                rd_data[CTL_EN]       = en_q;
                rd_data[CTL_START]    = busy;
                rd_data[CTL_DONE]     = done_q;
                rd_data[CTL_CHHI]     = chhi_q;
                rd_data[PSEL_W-1:0]   = psel_q;
            end
            A_DLO: rd_data = d_lo;
            A_DHI: rd_data = d_hi;
        endcase
    end
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       en_q,
    input logic       done_q,
    input logic [1:0] act_ref,
    input logic [5:0] act_chan
);
    // R3
    ref_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act_ref));

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(act_chan));

    // R8
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_q) |=> !busy);

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en_q) |=> (!busy && $stable(done_q)));
endmodule

bind adc_ctrl_regs adc_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .en_q     (en_q),
    .done_q   (done_q),
    .act_ref  (act_ref),
    .act_chan (act_chan)
);

// File: tb/adc_ctrl_regs_bench.sv
module adc_ctrl_regs_bench;
    localparam int N = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [9:0] conv_result = '0;
    logic [1:0] act_ref;
    logic [5:0] act_chan;
    logic       conv_active;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] cfg_sh = 8'h00;
    logic       chhi_sh = 1'b0;
    logic [2:0] psel_sh = 3'd0;

    always #5 clk = ~clk;

    adc_ctrl_regs u_adc_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .conv_result(conv_result), .act_ref(act_ref), .act_chan(act_chan),
        .conv_active(conv_active)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] ctl(input logic en, input logic st, input logic w1c);
        return {en, st, 1'b0, w1c, chhi_sh, psel_sh};
    endfunction

    task automatic wr_cfg(input logic [7:0] d);
        cfg_sh = d;
        wr(2'd0, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check(v == 8'h00, "R1 reg", v, 0);
        end
        check(act_ref == 2'b00 && act_chan == 6'd0 && !conv_active, "R1 outputs",
              {act_ref, act_chan, conv_active}, 0);
    endtask

    task automatic t_ref_track();
        wr(2'd1, ctl(1'b1, 1'b0, 1'b0));
        wr_cfg(8'h83);
        idle(1);
        check(act_ref == 2'b10, "R2 ref 1.5V", act_ref, 2);
        check(act_chan == 6'd3, "R4 chan follow", act_chan, 3);
        wr_cfg(8'h43);
        idle(1);
        check(act_ref == 2'b01, "R2 ref supply", act_ref, 1);
    endtask

    task automatic run_timed(input logic [2:0] ps, input string tag);
        logic [7:0] v;
        int dur;
        psel_sh = ps;
        dur = N * (1 << (ps + 1));
        wr(2'd1, ctl(1'b1, 1'b1, 1'b0));
        rd(2'd1, v);
        check(v[6] == 1'b1, {tag, " R6 start reads 1"}, v[6], 1);
        idle(dur - 1);
        check(conv_active == 1'b1, {tag, " R11 still busy at last cycle"}, conv_active, 1);
        idle(1);
        check(conv_active == 1'b0, {tag, " R11 ends on time"}, conv_active, 0);
        rd(2'd1, v);
        check(v[6] == 1'b0 && v[4] == 1'b1, {tag, " R7 done set, start clear"}, v, 8'h90);
    endtask

    task automatic t_conv_basic();
        logic [7:0] lo, hi;
        conv_result = 10'h2C5;
        run_timed(3'd0, "div2");
        rd(2'd2, lo); rd(2'd3, hi);
        check(lo == 8'hC5 && hi == 8'h02, "R10 R5 right", {hi, lo}, 16'h02C5);
        wr_cfg(8'h63);
        rd(2'd2, lo); rd(2'd3, hi);
        check(hi == 8'hB1 && lo == 8'h40, "R5 left", {hi, lo}, 16'hB140);
        wr_cfg(8'h43);
        conv_result = 10'h155;
        run_timed(3'd1, "div4");
        rd(2'd2, lo);
        check(lo == 8'h55, "R10 second capture", lo, 8'h55);
    endtask

    task automatic t_done_w1c();
        logic [7:0] v;
        wr(2'd1, ctl(1'b1, 1'b0, 1'b0));
        rd(2'd1, v);
        check(v[4] == 1'b1, "R7 write 0 keeps done", v[4], 1);
        wr(2'd1, ctl(1'b1, 1'b0, 1'b1));
        rd(2'd1, v);
        check(v[4] == 1'b0, "R7 write 1 clears", v[4], 0);
    endtask

    task automatic t_ref_freeze();
        wr_cfg(8'hC3);
        idle(2);
        check(act_ref == 2'b01, "R3 locked in hold", act_ref, 1);
        wr(2'd1, ctl(1'b0, 1'b0, 1'b0));
        wr(2'd1, ctl(1'b1, 1'b0, 1'b0));
        idle(2);
        check(act_ref == 2'b11, "R3 unlocked after re-enable", act_ref, 3);
    endtask

    task automatic t_chan_defer();
        logic [7:0] lo, hi;
        int guard;
        conv_result = 10'h13A;
        psel_sh = 3'd2;
        wr(2'd1, ctl(1'b1, 1'b1, 1'b0));
        idle(10);
        wr_cfg(8'hC5);
        chhi_sh = 1'b1;
        wr(2'd1, ctl(1'b1, 1'b0, 1'b0));
        idle(2);
        check(act_chan == 6'd3, "R4 chan deferred", act_chan, 3);
        check(conv_active == 1'b1, "R4 still converting", conv_active, 1);
        wr_cfg(8'hE5);
        rd(2'd3, hi);
        check(hi == 8'h55, "R5 ladj immediate mid-conv", hi, 8'h55);
        wr_cfg(8'hC5);
        guard = 0;
        while (conv_active && guard < 500) begin idle(1); guard++; end
        idle(1);
        check(act_chan == 6'h25, "R4 chan applied after done", act_chan, 6'h25);
        rd(2'd2, lo); rd(2'd3, hi);
        check(lo == 8'h3A && hi == 8'h01, "R10 capture", {hi, lo}, 16'h013A);
        wr(2'd1, ctl(1'b1, 1'b0, 1'b1));
    endtask

    task automatic t_disabled_start();
        logic [7:0] v;
        wr(2'd1, ctl(1'b0, 1'b0, 1'b0));
        wr(2'd1, ctl(1'b0, 1'b1, 1'b0));
        idle(2);
        check(conv_active == 1'b0, "R8 start while off", conv_active, 0);
        wr(2'd1, ctl(1'b1, 1'b1, 1'b0));
        idle(2);
        rd(2'd1, v);
        check(conv_active == 1'b0 && v[7:6] == 2'b10, "R8 start with enable", v, 8'h80);
    endtask

    task automatic t_abort();
        logic [7:0] v, lo;
        conv_result = 10'h3FF;
        wr(2'd1, ctl(1'b1, 1'b1, 1'b0));
        idle(20);
        check(conv_active == 1'b1, "R9 running before abort", conv_active, 1);
        wr(2'd1, ctl(1'b0, 1'b0, 1'b0));
        idle(1);
        check(conv_active == 1'b0, "R9 aborted", conv_active, 0);
        idle(200);
        rd(2'd1, v);
        check(v[4] == 1'b0, "R9 no done after abort", v[4], 0);
        rd(2'd2, lo);
        check(lo == 8'h3A, "R9 result not captured", lo, 8'h3A);
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_ref_track();
        t_conv_basic();
        t_done_w1c();
        t_ref_freeze();
        t_chan_defer();
        t_disabled_start();
        t_abort();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule